// File: doc/BRIEF.md
# Two-Port Same-Address Collision Arbiter

This block watches the two independent ports of a shared word array. On each rising clock edge it checks whether both ports are selected and pointing at the same word. When they are, it names one port the owner. The owner is the port whose selection and address were already held on the previous edge. If neither or both were already held, the left port is chosen. The other port then sees its active-low busy flag go low, and its write strobe to the array is suppressed for as long as the owner keeps the same word selected. Reads are never gated. The block produces only write strobes and busy flags.

A mode input picks between two roles. In the arbitrating role the block drives its busy outputs from its own decision. In the follower role local arbitration is switched off, both busy outputs stay high, and a pair of externally supplied busy inputs gates the writes instead. Several devices can then share the decision of one arbitrating device. Tying both external inputs high in the follower role turns write inhibition off altogether.

Top module: `dp_collide_arb`

## Requirements
- R1: A collision is recognised only when both select inputs are low and both ADDR_W-bit addresses are equal. The write request inputs play no part in it. With `mode_arb` high, a collision sampled on an edge drives exactly one busy output low after that edge.
- R2: The owner is the port that held the same select and address on the previous edge. The other port's busy output is low from the edge on which the collision is first sampled.
- R3: The two busy outputs are never low together. When both ports reach the matching address on the same edge, the left port owns and `r_busy_n` goes low.
- R4: The busy output returns high after the first edge on which the addresses differ or either select is high. If the owner moves away while the other port holds the address, ownership passes to the port that held it.
- R5: `l_wr_go` = `l_wr_req` AND NOT `l_sel_n` AND NOT the effective left busy. `r_wr_go` follows the same rule. The effective busy is the registered arbiter busy in the arbitrating role and the external input in the follower role. The strobe follows the current request within the same cycle.
- R6: With `mode_arb` low, both busy outputs are high from the next edge on. A low `l_busy_in_n` or `r_busy_in_n` blocks that port's write strobe.
- R7: In the follower role, with both external busy inputs high, a matching-address write from either port is not blocked.
- R8: While `rst_n` is low and after its release, both busy outputs are high until a collision is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_arb | input | 1 | 1 = local arbitration, 0 = follow external busy |
| l_sel_n | input | 1 | Left port select, active low |
| l_addr | input | ADDR_W | Left port word address |
| l_wr_req | input | 1 | Left port write request |
| l_busy_in_n | input | 1 | External busy for the left port (follower role) |
| r_sel_n | input | 1 | Right port select, active low |
| r_addr | input | ADDR_W | Right port word address |
| r_wr_req | input | 1 | Right port write request |
| r_busy_in_n | input | 1 | External busy for the right port (follower role) |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_go | output | 1 | Left write strobe to the array |
| r_wr_go | output | 1 | Right write strobe to the array |

## Verification
The bench goes after several orderings. In one, the right port joins an address the left already holds; a design that ignored arrival order would flag the wrong side. Another case has both ports arriving on one edge, where a missing tie-break would flag both ports or neither. The bench also moves the owner away while the loser stays on the word, and a design that only cleared ownership would leave the waiting port unprotected for a cycle. Role switches check that the external inputs, and not stale local state, gate writes, and that with both inputs high no write is ever dropped.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              prev_sel_q, prev_sel_d;
  logic [ADDR_W-1:0] prev_addr_q, prev_addr_d;
  logic              addr_en;

  always_comb begin
    prev_sel_d  = ~sel_n;
    addr_en     = ~sel_n;
    prev_addr_d = addr;
    held        = ~sel_n & prev_sel_q & (prev_addr_q == addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_sel_q <= prev_sel_d;
      if (addr_en) prev_addr_q <= prev_addr_d;
    end
  end
endmodule

// File: rtl/dpa_owner_fsm.sv
module dpa_owner_fsm
  import dpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_arb,
  input  logic match,
  input  logic l_held,
  input  logic r_held,
  output logic l_lost,
  output logic r_lost
);
  owner_e own_q, own_d;
  logic   winner_held;

  always_comb begin
    winner_held = ((own_q == OWN_LEFT) & l_held) | ((own_q == OWN_RIGHT) & r_held);
    if (!mode_arb || !match)      own_d = OWN_NONE;
    else if (winner_held)         own_d = own_q;
    else if (r_held && !l_held)   own_d = OWN_RIGHT;
    else                          own_d = OWN_LEFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign l_lost = (own_q == OWN_RIGHT);
  assign r_lost = (own_q == OWN_LEFT);
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
  input  logic mode_arb,
  input  logic sel_n,
  input  logic wr_req,
  input  logic local_lost,
  input  logic ext_busy_n,
  output logic wr_go
);
  logic blocked;

  always_comb begin
    blocked = mode_arb ? local_lost : ~ext_busy_n;
    wr_go   = wr_req & ~sel_n & ~blocked;
  end
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_arb,
  input  logic              l_sel_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr_req,
  input  logic              l_busy_in_n,
  input  logic              r_sel_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr_req,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_go,
  output logic              r_wr_go
);
  logic match, l_held, r_held, l_lost, r_lost;

  assign match = ~l_sel_n & ~r_sel_n & (l_addr == r_addr);

  dpa_port_track #(.ADDR_W(ADDR_W)) u_trk_l (
    .clk(clk), .rst_n(rst_n), .sel_n(l_sel_n), .addr(l_addr), .held(l_held));
  dpa_port_track #(.ADDR_W(ADDR_W)) u_trk_r (
    .clk(clk), .rst_n(rst_n), .sel_n(r_sel_n), .addr(r_addr), .held(r_held));

  dpa_owner_fsm u_own (
    .clk(clk), .rst_n(rst_n), .mode_arb(mode_arb), .match(match),
    .l_held(l_held), .r_held(r_held), .l_lost(l_lost), .r_lost(r_lost));

  dpa_write_gate u_gate_l (
    .mode_arb(mode_arb), .sel_n(l_sel_n), .wr_req(l_wr_req),
    .local_lost(l_lost), .ext_busy_n(l_busy_in_n), .wr_go(l_wr_go));
  dpa_write_gate u_gate_r (
    .mode_arb(mode_arb), .sel_n(r_sel_n), .wr_req(r_wr_req),
    .local_lost(r_lost), .ext_busy_n(r_busy_in_n), .wr_go(r_wr_go));

  assign l_busy_n = ~l_lost;
  assign r_busy_n = ~r_lost;
endmodule

// File: rtl/dp_collide_arb_chk.sv
module dp_collide_arb_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_arb,
  input logic              l_sel_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_in_n,
  input logic              r_sel_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_wr_go,
  input logic              r_wr_go
);
  logic coll;
  assign coll = ~l_sel_n & ~r_sel_n & (l_addr == r_addr);

  p_one_loser_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  p_collide_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_arb && coll) |=> (!l_busy_n || !r_busy_n));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !coll |=> (l_busy_n && r_busy_n));

  p_follow_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_arb |=> (l_busy_n && r_busy_n));

  p_block_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_arb && !l_busy_n) |-> !l_wr_go);

  p_block_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_arb && !r_busy_n) |-> !r_wr_go);

  p_ext_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_arb && (!l_busy_in_n || !r_busy_in_n)) |->
      !((!l_busy_in_n && l_wr_go) || (!r_busy_in_n && r_wr_go)));
endmodule

bind dp_collide_arb dp_collide_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_arb(mode_arb),
  .l_sel_n(l_sel_n), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
  .r_sel_n(r_sel_n), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_go(l_wr_go), .r_wr_go(r_wr_go));

// File: tb/dp_collide_arb_bench.sv
module dp_collide_arb_bench;
  localparam int AW = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_arb = 1'b1;
  logic l_sel_n = 1'b1, r_sel_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_wr_req = 1'b0, r_wr_req = 1'b0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic l_busy_n, r_busy_n, l_wr_go, r_wr_go;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference: 0 none, 1 left owns, 2 right owns
  int m_own = 0;
  bit m_lp_en = 0, m_rp_en = 0;
  int m_lp_a = 0, m_rp_a = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_collide_arb #(.ADDR_W(AW)) u_dp_collide_arb (
    .clk(clk), .rst_n(rst_n), .mode_arb(mode_arb),
    .l_sel_n(l_sel_n), .l_addr(l_addr), .l_wr_req(l_wr_req), .l_busy_in_n(l_busy_in_n),
    .r_sel_n(r_sel_n), .r_addr(r_addr), .r_wr_req(r_wr_req), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_go(l_wr_go), .r_wr_go(r_wr_go));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = 0; m_lp_en = 0; m_rp_en = 0; m_lp_a = 0; m_rp_a = 0;
    end else begin
      bit same, lh, rh;
      same = !l_sel_n && !r_sel_n && (l_addr == r_addr);
      lh = !l_sel_n && m_lp_en && (m_lp_a == int'(l_addr));
      rh = !r_sel_n && m_rp_en && (m_rp_a == int'(r_addr));
      if (!mode_arb || !same) m_own = 0;
      else if ((m_own == 1 && lh) || (m_own == 2 && rh)) m_own = m_own;
      else if (rh && !lh) m_own = 2;
      else m_own = 1;
      m_lp_en = !l_sel_n; m_rp_en = !r_sel_n;
      if (!l_sel_n) m_lp_a = int'(l_addr);
      if (!r_sel_n) m_rp_a = int'(r_addr);
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every output against the reference model
  task automatic cmp_model();
    bit lb, rb;
    lb = mode_arb ? (m_own == 2) : !l_busy_in_n;
    rb = mode_arb ? (m_own == 1) : !r_busy_in_n;
    check("R3 l_busy_n model", l_busy_n, !(m_own == 2));
    check("R2 r_busy_n model", r_busy_n, !(m_own == 1));
    check("R5 l_wr_go model", l_wr_go, l_wr_req && !l_sel_n && !lb);
    check("R5 r_wr_go model", r_wr_go, r_wr_req && !r_sel_n && !rb);
  endtask

  // drive after the falling edge, let the next rising edge pass, compare after it
  task automatic cyc(input bit m, input bit ls, input int la, input bit lw, input bit lbi,
                     input bit rs, input int ra, input bit rw, input bit rbi);
    @(negedge clk);
    mode_arb = m; l_sel_n = ls; l_addr = AW'(la); l_wr_req = lw; l_busy_in_n = lbi;
    r_sel_n = rs; r_addr = AW'(ra); r_wr_req = rw; r_busy_in_n = rbi;
    @(posedge clk); #1;
    cmp_model();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R8 l_busy_n in reset", l_busy_n, 1'b1);
    check("R8 r_busy_n in reset", r_busy_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 1,0,0,1, 1,0,0,1);
    check("R8 l_busy_n after reset", l_busy_n, 1'b1);
    check("R8 r_busy_n after reset", r_busy_n, 1'b1);

    // R2: left holds 5, right joins with a write
    cyc(1, 0,5,0,1, 1,0,0,1);
    cyc(1, 0,5,0,1, 0,5,1,1);
    check("R2 right loses", r_busy_n, 1'b0);
    check("R2 left keeps", l_busy_n, 1'b1);
    check("R5 right write blocked", r_wr_go, 1'b0);
    cyc(1, 0,5,1,1, 0,5,1,1);
    check("R5 left write passes", l_wr_go, 1'b1);
    check("R5 right still blocked", r_wr_go, 1'b0);
    // R4: left deselects, release
    cyc(1, 1,5,0,1, 0,5,1,1);
    check("R4 release r_busy_n", r_busy_n, 1'b1);
    check("R4 right write resumes", r_wr_go, 1'b1);

    // R3: simultaneous arrival, left favoured
    cyc(1, 1,0,0,1, 1,0,0,1);
    cyc(1, 0,9,0,1, 0,9,0,1);
    check("R3 tie right busy", r_busy_n, 1'b0);
    check("R3 tie left free", l_busy_n, 1'b1);

    // R4 handover: left owner leaves to 3 then returns? right held at 9, left moves to 9 again next
    cyc(1, 0,3,0,1, 0,9,0,1);
    check("R4 mismatch clears", r_busy_n, 1'b1);
    cyc(1, 0,9,1,1, 0,9,0,1);
    check("R2 right held wins", l_busy_n, 1'b0);
    check("R5 left blocked", l_wr_go, 1'b0);

    // R1: different addresses, writes on both
    cyc(1, 0,1,1,1, 0,2,1,1);
    check("R1 no collision l", l_busy_n, 1'b1);
    check("R1 no collision r", r_busy_n, 1'b1);
    check("R1 writes pass", l_wr_go & r_wr_go, 1'b1);

    // R6: follower role, external busy gates writes
    cyc(0, 0,4,1,0, 0,4,1,1);
    cyc(0, 0,4,1,0, 0,4,1,1);
    check("R6 ext busy blocks left", l_wr_go, 1'b0);
    check("R6 right passes", r_wr_go, 1'b1);
    check("R6 busy outputs high", l_busy_n & r_busy_n, 1'b1);
    // R7: both inputs high, matching writes unblocked
    cyc(0, 0,4,1,1, 0,4,1,1);
    check("R7 left not inhibited", l_wr_go, 1'b1);
    check("R7 right not inhibited", r_wr_go, 1'b1);

    // mixed traffic against the reference
    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 8) != 0, $urandom % 3 == 0, $urandom % 3, $urandom % 2, $urandom % 4 != 0,
          $urandom % 3 == 0, $urandom % 3, $urandom % 2, $urandom % 4 != 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule